// File: doc/BRIEF.md
# Row-Column Fault Locator with XOR Compaction

This unit runs the diagnosis of a square array of N by N logic cells, of which at most one is faulty, and reports where the faulty cell lies. A diagnosis starts with a start pulse. The unit then runs two passes, one after the other. In the row pass every row of cells is chained left to right and drives one response line, so the N response lines carry one bit per row. In the column pass the chaining is turned through ninety degrees and each line carries one column. The column pass always runs, whatever the row pass found.

Each pass walks through 2K+4 cell configurations, where K is the number of lookup inputs of a cell, so the two passes together use 4K+8. For every response the driving logic presents the observed and expected bits of all N lines. Any mismatch sets a sticky flag for that line. When both passes are over, the row flag and the column flag together give the cell coordinates.

In compaction mode the cells at alternate positions of a line act as a 2-input XOR chain that merges the outputs of the cells under test. The three configurations that pass through a cell flip-flop are each run twice, the second time with the tested and merging roles exchanged. Because no flip-flop chain remains, every response arrives one cycle after its pattern instead of N cycles after it.

Top module: `fdiag_top`

## Requirements
- R1: After reset, busy, done, pass_vert, fault_found and ambiguous are low. A start pulse while idle or done latches compact_en, clears all line flags, and enters the row pass at configuration 0 (busy high, pass_vert low).
- R2: In the row pass, a cycle with resp_valid high and obs_bits[i] different from exp_bits[i] sets row flag i. A cycle with resp_valid and resp_last both high ends the current configuration run, and the configuration index counts 0 to 2K+3.
- R3: The column pass (pass_vert high) always follows the row pass, with the same configuration count. Its mismatches set column flags. After its last run the unit is done (busy low, done high).
- R4: Line flags are sticky for the rest of the diagnosis. Mismatches presented while resp_valid is low have no effect on any flag.
- R5: In compaction mode, configurations 2K, 2K+1 and 2K+3 are each run twice: first with role_swap low, then with role_swap high. This gives 2K+7 runs per pass. Outside compaction mode role_swap stays low and each pass has 2K+4 runs.
- R6: resp_lat gives the response latency of the current run in cycles. It is N for configurations 2K, 2K+1 and 2K+3 without compaction, and 1 in every other case.
- R7: While done, fault_found is high if any row or column flag is set. fault_row and fault_col are the zero-based index of the lowest flagged row and column (0 when none is flagged). ambiguous is high if more than one row or more than one column is flagged.
- R8: A start pulse during a pass is ignored. The pass and configuration index change only on a cycle with resp_valid and resp_last both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new diagnosis |
| compact_en | input | 1 | Select compaction mode for the diagnosis being started |
| resp_valid | input | 1 | The response bits this cycle are to be compared |
| resp_last | input | 1 | Last response of the current configuration run |
| obs_bits | input | N | Observed response per line |
| exp_bits | input | N | Expected response per line |
| busy | output | 1 | A pass is in progress |
| pass_vert | output | 1 | The column pass is active |
| cfg_idx | output | clog2(2K+4) | Current configuration index |
| role_swap | output | 1 | Tested and merging cell roles are exchanged |
| resp_lat | output | clog2(N+1) | Response latency of the current run |
| done | output | 1 | Both passes are complete |
| fault_found | output | 1 | At least one line was flagged |
| ambiguous | output | 1 | Multiple rows or columns were flagged |
| fault_row | output | clog2(N) | Faulty row index |
| fault_col | output | clog2(N) | Faulty column index |

## Verification
A sequencer that counts wrong shows up at once on cfg_idx, role_swap and resp_lat. Over a whole diagnosis it also shows as a pass that takes the wrong number of response runs, which is visible in the cycle where pass_vert or done changes. A flag that is lost, cleared early or set by an invalid cycle stays hidden until done rises. At that point it appears as a wrong coordinate, a wrong fault_found or a wrong ambiguous. For that reason the errors are injected only in the first run of each pass, and a clean diagnosis follows a faulty one.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HORZ = 2'd1,
        ST_VERT = 2'd2,
        ST_DONE = 2'd3
    } fdiag_state_e;
endpackage

// File: rtl/fdiag_seq.sv
module fdiag_seq
    import fdiag_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              compact_en,
    input  logic                              resp_valid,
    input  logic                              resp_last,
    output fdiag_state_e                      state,
    output logic [$clog2(2*K+4)-1:0]          cfg_idx,
    output logic                              role_swap,
    output logic                              clr,
    output logic [$clog2(N+1)-1:0]            resp_lat
);
    localparam int CFG_W  = $clog2(2*K+4);
    localparam int LAT_W  = $clog2(N+1);
    localparam int LAST   = 2*K+3;
    localparam int FF_A   = 2*K;
    localparam int FF_B   = 2*K+1;
    localparam int FF_C   = 2*K+3;

    typedef struct packed {
        fdiag_state_e     st;
        logic [CFG_W-1:0] cfg;
        logic             swap;
        logic             cmp;
    } seq_t;

    seq_t s_d, s_q;
    logic is_dbl;
    logic run_end;

    always_comb begin
        s_d     = s_q;
        clr     = 1'b0;
        is_dbl  = (s_q.cfg == CFG_W'(FF_A)) || (s_q.cfg == CFG_W'(FF_B)) ||
                  (s_q.cfg == CFG_W'(FF_C));
        run_end = resp_valid && resp_last;
        case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    s_d.st   = ST_HORZ;
                    s_d.cfg  = '0;
                    s_d.swap = 1'b0;
                    s_d.cmp  = compact_en;
                    clr      = 1'b1;
                end
            end
            default: begin
                if (run_end) begin
                    if (s_q.cmp && is_dbl && !s_q.swap) begin
                        s_d.swap = 1'b1;
                    end else begin
                        s_d.swap = 1'b0;
                        if (s_q.cfg == CFG_W'(LAST)) begin
                            s_d.cfg = '0;
                            s_d.st  = (s_q.st == ST_HORZ) ? ST_VERT : ST_DONE;
                        end else begin
                            s_d.cfg = s_q.cfg + CFG_W'(1);
                        end
                    end
                end
            end
        endcase
        resp_lat = (!s_q.cmp && is_dbl) ? LAT_W'(N) : LAT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cfg: '0, swap: 1'b0, cmp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state     = s_q.st;
    assign cfg_idx   = s_q.cfg;
    assign role_swap = s_q.swap;

    // R3: the column pass always follows the final row-pass run
    a_r3_vert_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HORZ && s_q.cfg == CFG_W'(LAST) && resp_valid && resp_last &&
         (s_q.swap || !s_q.cmp)) |=> (s_q.st == ST_VERT && s_q.cfg == '0));

    // R5: the swapped run exists only for the doubled configurations in compaction mode
    a_r5_swap_legal: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.swap |-> (s_q.cmp && is_dbl));

    // R5: a swapped run is always followed by a fresh configuration
    a_r5_swap_then_next: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.swap && resp_valid && resp_last) |=> !s_q.swap);

    // R8: during a pass nothing moves without the end of a run
    a_r8_hold_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_HORZ || s_q.st == ST_VERT) && !(resp_valid && resp_last))
        |=> ($stable(s_q.cfg) && $stable(s_q.st) && $stable(s_q.swap)));
endmodule

// File: rtl/fdiag_errmap.sv
module fdiag_errmap #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         row_en,
    input  logic         col_en,
    input  logic [N-1:0] obs_bits,
    input  logic [N-1:0] exp_bits,
    output logic [N-1:0] row_err,
    output logic [N-1:0] col_err
);
    typedef struct packed {
        logic [N-1:0] row;
        logic [N-1:0] col;
    } err_t;

    err_t         e_d, e_q;
    logic [N-1:0] miss;

    always_comb begin
        e_d  = e_q;
        miss = obs_bits ^ exp_bits;
        if (clr) begin
            e_d.row = '0;
            e_d.col = '0;
        end else begin
            if (row_en) e_d.row = e_q.row | miss;
            if (col_en) e_d.col = e_q.col | miss;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign row_err = e_q.row;
    assign col_err = e_q.col;

    // R4: without a clear, no flag that is set ever drops
    a_r4_sticky_row: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((e_q.row & $past(e_q.row)) == $past(e_q.row)));
    a_r4_sticky_col: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((e_q.col & $past(e_q.col)) == $past(e_q.col)));
    // R4: no flag changes without a valid response or a clear
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !row_en && !col_en) |=> $stable(e_q));
endmodule

// File: rtl/fdiag_locate.sv
module fdiag_locate #(
    parameter int N = 8
) (
    input  logic [N-1:0]         flags,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any,
    output logic                 multi
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) idx = IDX_W'(i);
        end
        any   = |flags;
        multi = |(flags & (flags - N'(1)));
    end

    // R7: a reported index points at a flagged line with none below it
    always_comb begin
        if (any) begin
            a_r7_idx_flagged: assert (flags[idx] && ((flags & ((N'(1) << idx) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/fdiag_top.sv
module fdiag_top
    import fdiag_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         compact_en,
    input  logic                         resp_valid,
    input  logic                         resp_last,
    input  logic [N-1:0]                 obs_bits,
    input  logic [N-1:0]                 exp_bits,
    output logic                         busy,
    output logic                         pass_vert,
    output logic [$clog2(2*K+4)-1:0]     cfg_idx,
    output logic                         role_swap,
    output logic [$clog2(N+1)-1:0]       resp_lat,
    output logic                         done,
    output logic                         fault_found,
    output logic                         ambiguous,
    output logic [$clog2(N)-1:0]         fault_row,
    output logic [$clog2(N)-1:0]         fault_col
);
    localparam int IDX_W = $clog2(N);

    fdiag_state_e     st;
    logic             clr;
    logic [N-1:0]     row_err, col_err;
    logic [IDX_W-1:0] row_idx, col_idx;
    logic             row_any, col_any, row_multi, col_multi;

    fdiag_seq #(.N(N), .K(K)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .compact_en (compact_en),
        .resp_valid (resp_valid),
        .resp_last  (resp_last),
        .state      (st),
        .cfg_idx    (cfg_idx),
        .role_swap  (role_swap),
        .clr        (clr),
        .resp_lat   (resp_lat)
    );

    fdiag_errmap #(.N(N)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .row_en   (resp_valid && st == ST_HORZ),
        .col_en   (resp_valid && st == ST_VERT),
        .obs_bits (obs_bits),
        .exp_bits (exp_bits),
        .row_err  (row_err),
        .col_err  (col_err)
    );

    fdiag_locate #(.N(N)) u_row (
        .flags (row_err),
        .idx   (row_idx),
        .any   (row_any),
        .multi (row_multi)
    );

    fdiag_locate #(.N(N)) u_col (
        .flags (col_err),
        .idx   (col_idx),
        .any   (col_any),
        .multi (col_multi)
    );

    always_comb begin
        busy        = (st == ST_HORZ) || (st == ST_VERT);
        pass_vert   = (st == ST_VERT);
        done        = (st == ST_DONE);
        fault_found = done && (row_any || col_any);
        ambiguous   = done && (row_multi || col_multi);
        fault_row   = done ? row_idx : '0;
        fault_col   = done ? col_idx : '0;
    end

    // R1: a diagnosis leaves idle or done only through a start pulse
    a_r1_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !pass_vert && cfg_idx == '0));

    // R7: the ambiguity flag is only raised alongside a found fault
    a_r7_amb_implies_found: assert property (@(posedge clk) disable iff (!rst_n)
        ambiguous |-> fault_found);
endmodule

// File: tb/sim_fdiag_top.sv
module sim_fdiag_top;
    localparam int N       = 8;
    localparam int K       = 4;
    localparam int CLK_PER = 10;
    localparam int NVEC    = 7;

    // {compact, row-pass error mask, column-pass error mask, found, ambiguous, row, col}
    localparam logic [24:0] VECS [NVEC] = '{
        {1'b0, 8'h04, 8'h20, 1'b1, 1'b0, 3'd2, 3'd5},
        {1'b1, 8'h80, 8'h01, 1'b1, 1'b0, 3'd7, 3'd0},
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0},
        {1'b1, 8'h12, 8'h08, 1'b1, 1'b1, 3'd1, 3'd3},
        {1'b0, 8'h01, 8'h40, 1'b1, 1'b0, 3'd0, 3'd6},
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0},
        {1'b0, 8'h04, 8'h00, 1'b1, 1'b0, 3'd2, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n, start, compact_en, resp_valid, resp_last;
    logic [N-1:0] obs_bits, exp_bits;
    logic       busy, pass_vert, role_swap, done, fault_found, ambiguous;
    logic [3:0] cfg_idx;
    logic [3:0] resp_lat;
    logic [2:0] fault_row, fault_col;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    fdiag_top #(.N(N), .K(K)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .compact_en(compact_en),
        .resp_valid(resp_valid), .resp_last(resp_last),
        .obs_bits(obs_bits), .exp_bits(exp_bits),
        .busy(busy), .pass_vert(pass_vert), .cfg_idx(cfg_idx), .role_swap(role_swap),
        .resp_lat(resp_lat), .done(done), .fault_found(fault_found),
        .ambiguous(ambiguous), .fault_row(fault_row), .fault_col(fault_col)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // runs one pass; the error mask is applied only in the first run
    task automatic run_pass(input bit vert, input bit cmp, input logic [N-1:0] mask,
                            output int runs, output int swaps);
        int s = 0;
        swaps = 0;
        while (busy && (pass_vert == vert) && s < 40) begin
            int el;
            el = (!cmp && (cfg_idx == 4'd8 || cfg_idx == 4'd9 || cfg_idx == 4'd11)) ? N : 1;
            check(int'(resp_lat) == el, "R6 resp_lat", int'(resp_lat), el);
            if (role_swap) swaps++;
            exp_bits   = N'(s * 37 + 11);
            obs_bits   = exp_bits ^ ((s == 0) ? mask : '0);
            resp_valid = 1'b1;
            resp_last  = 1'b1;
            @(negedge clk);
            s++;
        end
        resp_valid = 1'b0;
        resp_last  = 1'b0;
        runs = s;
    endtask

    task automatic run_case(input logic [24:0] v);
        int hr, hs, vr, vs, er;
        @(negedge clk);
        start = 1'b1;
        compact_en = v[24];
        @(negedge clk);
        start = 1'b0;
        compact_en = 1'b0;
        check(busy && !pass_vert && cfg_idx == 4'd0, "R1 start enters row pass", int'(busy), 1);
        run_pass(1'b0, v[24], v[23:16], hr, hs);
        er = v[24] ? 2*K+7 : 2*K+4;
        check(hr == er, "R2 row pass runs", hr, er);
        check(pass_vert && busy, "R3 column pass follows", int'(pass_vert), 1);
        run_pass(1'b1, v[24], v[15:8], vr, vs);
        check(vr == er, "R3 column pass runs", vr, er);
        check(hs == (v[24] ? 3 : 0), "R5 row pass swapped runs", hs, v[24] ? 3 : 0);
        check(vs == (v[24] ? 3 : 0), "R5 column pass swapped runs", vs, v[24] ? 3 : 0);
        check(done && !busy, "R3 done after column pass", int'(done), 1);
        check(fault_found == v[7], "R7 fault_found", int'(fault_found), int'(v[7]));
        check(ambiguous == v[6], "R7 ambiguous", int'(ambiguous), int'(v[6]));
        check(fault_row == v[5:3], "R7 fault_row", int'(fault_row), int'(v[5:3]));
        check(fault_col == v[2:0], "R7 fault_col (R4 sticky)", int'(fault_col), int'(v[2:0]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; compact_en = 1'b0;
        resp_valid = 1'b0; resp_last = 1'b0; obs_bits = '0; exp_bits = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !pass_vert, "R1 reset state", int'(busy || done), 0);
        check(!fault_found && !ambiguous, "R1 reset flags", int'(fault_found), 0);

        for (int i = 0; i < NVEC; i++) run_case(VECS[i]);

        // R4 and R8: invalid mismatches and a start in mid-pass have no effect
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 3; j++) begin
            exp_bits = 8'h5A; obs_bits = 8'h5A;
            resp_valid = 1'b1; resp_last = 1'b1;
            @(negedge clk);
        end
        resp_valid = 1'b0; resp_last = 1'b0;
        obs_bits = 8'hFF; exp_bits = 8'h00;
        @(negedge clk);
        check(cfg_idx == 4'd3, "R8 hold without run end", int'(cfg_idx), 3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_idx == 4'd3 && busy && !pass_vert, "R8 start ignored in pass", int'(cfg_idx), 3);
        begin
            int r1, s1, r2, s2;
            run_pass(1'b0, 1'b0, '0, r1, s1);
            run_pass(1'b1, 1'b0, '0, r2, s2);
            check(r1 == 9, "R8 remaining row runs", r1, 9);
        end
        check(done && !fault_found, "R4 invalid mismatch ignored", int'(fault_found), 0);
        finish_run();
    end
endmodule